// File: doc/BRIEF.md
# SD Host Command and Status Register File

This block is the software-facing register set of an SD card host controller, reached over a 16-bit register bus. Software loads a 32-bit command argument and a 16-bit command word. That word packs the opcode, the kind of response expected from the card, and whether a data phase follows and in which direction. Writing the command word sends a start pulse, along with the decoded fields, to the command engine that drives the card lines. The engine returns a 32-bit response and a set of event pulses. The events are collected in a sticky status register, and an interrupt mask decides which status bits raise the interrupt line.

Every 32-bit register is exposed as two 16-bit halves. The low half sits at an even word offset and the high half sits two bytes above it. Status bits are cleared by writing zero to them, so software can acknowledge one event without disturbing the others. The block also holds a card clock control register, which is locked while a command is in flight, and a bus-width option register. A soft reset register holds the controller core in reset while its bit 0 is zero.

Top module: `sdh_regs`

Byte offsets: argument 0x00/0x02, command word 0x04, clock control 0x06, response 0x08/0x0A, status 0x0C/0x0E, interrupt mask 0x10/0x12, option 0x14, soft reset 0x16. Address bit 0 is ignored. A read returns data one cycle after the read strobe, on `bus_rdata_o`. An unmapped offset reads as zero.

## Requirements
- R1: After reset, the registers hold these values: status 0, interrupt mask 0xFFFFFFFF, clock control 0x0040, option 0x80E0, soft reset 0x0001, argument and response 0. After reset `irq_o`, `err_o`, `cmd_start_o` and `core_rst_o` are all 0.
- R2: The argument register is written and read as two halves, with bits 15:0 at 0x00 and bits 31:16 at 0x02. `cmd_arg_o` shows the full 32-bit value after the write edge.
- R3: Status bits 15:0 are at 0x0C and bits 31:16 are at 0x0E. A status write clears each stored bit whose data bit is 0 and leaves each bit whose data bit is 1 unchanged.
- R4: A high bit of `evt_i` sets the matching status bit at the next edge. A set takes priority over a clear written in the same cycle. Only bits 3:0 (completion group) and 24:16 (error group) are stored. All other event bits read back as 0.
- R5: `irq_o` is the OR of all status bits whose mask bit is 0. It follows the status register by one cycle.
- R6: The command word layout is opcode in bits 5:0, response kind in bits 10:8, data-phase flag in bit 11 and read-direction flag in bit 12. The command word is readable at 0x04. After the write edge, `cmd_opcode_o`, `cmd_resp_type_o`, `cmd_data_o` and `cmd_read_o` show these fields.
- R7: A write to 0x04 whose response kind is 3 through 7 raises `cmd_start_o` for exactly the one cycle after the write edge. The kinds are 3 none, 4 short, 5 short with busy, 6 long, 7 operating-conditions. A kind of 0 to 2 gives no start pulse.
- R8: `cmd_busy_i` reads back as status bit 30 (bit 14 at 0x0E). Writes cannot change this bit.
- R9: A write to the clock control register is ignored while `cmd_busy_i` is high. `clk_en_o` is bit 8 and `clk_div_o` is bits 7:0.
- R10: `bus4_o` is the inverse of option bit 15, so 0x80E0 selects a 1-bit bus and 0x00E0 selects a 4-bit bus.
- R11: While soft reset bit 0 is 0, `core_rst_o` is 1 and the status and response registers are cleared and ignore events. Writing 1 to the bit releases the core.
- R12: When `resp_valid_i` is high, `resp_i` is captured. The response reads at 0x08 (bits 15:0) and 0x0A (bits 31:16).
- R13: `err_o` is 1 in the cycle after any error-group status bit (24:16) is set, regardless of the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| evt_i | input | 32 | Event pulses from the command engine |
| cmd_busy_i | input | 1 | Command in flight |
| resp_valid_i | input | 1 | Response capture strobe |
| resp_i | input | 32 | Card response |
| cmd_start_o | output | 1 | One-cycle command start |
| cmd_opcode_o | output | 6 | Command opcode |
| cmd_resp_type_o | output | 3 | Response kind |
| cmd_data_o | output | 1 | Data phase follows |
| cmd_read_o | output | 1 | Data phase is card to host |
| cmd_arg_o | output | 32 | Command argument |
| irq_o | output | 1 | Unmasked status present |
| err_o | output | 1 | Any error-group status set |
| clk_en_o | output | 1 | Card clock enable |
| clk_div_o | output | 8 | Card clock divider code |
| bus4_o | output | 1 | 4-bit data bus selected |
| core_rst_o | output | 1 | Controller core held in reset |

## Verification
The hardest case to reach from the ports is an event pulse and a software clear hitting the same status bit on the same clock edge. Only in that cycle does the set-over-clear priority decide the result. The bench drives the write strobe and the event bit in the same low clock phase, so both land on one edge. Two other cases need deliberate port timing. The clock-control lockout needs a write issued while the busy input is held high. The soft-reset window needs events delivered between the write of 0 and the write of 1.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
  localparam int BUS_W = 16;

  // byte offsets of the register halves
  localparam int OFF_ARG  = 'h00;
  localparam int OFF_CMD  = 'h04;
  localparam int OFF_CLK  = 'h06;
  localparam int OFF_RESP = 'h08;
  localparam int OFF_STAT = 'h0C;
  localparam int OFF_MASK = 'h10;
  localparam int OFF_OPT  = 'h14;
  localparam int OFF_SRST = 'h16;

  // status groups
  localparam logic [31:0] DONE_GROUP = 32'h0000_000F;
  localparam logic [31:0] ERR_GROUP  = 32'h01FF_0000;
  localparam logic [31:0] STAT_IMPL  = DONE_GROUP | ERR_GROUP;
  localparam int          BUSY_BIT   = 30;

  localparam logic [15:0] CLK_RST_VAL = 16'h0040;
  localparam logic [15:0] OPT_RST_VAL = 16'h80E0;
  localparam int          CLK_EN_BIT  = 8;
  localparam int          OPT_NARROW  = 15;

  localparam logic [2:0] RK_FIRST_VALID = 3'd3;

  typedef struct packed {
    logic [2:0] spare_hi;
    logic       rd;
    logic       data;
    logic [2:0] rkind;
    logic [1:0] spare_lo;
    logic [5:0] opcode;
  } cmd_word_t;
endpackage

// File: rtl/sdh_status.sv
module sdh_status
  import sdh_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                soft_rst,
  input  logic [1:0]          st_wr,
  input  logic [1:0]          mk_wr,
  input  logic [HALF_W-1:0]   wdata,
  input  logic [2*HALF_W-1:0] evt,
  input  logic                busy,
  output logic [2*HALF_W-1:0] status_rd,
  output logic [2*HALF_W-1:0] mask_rd,
  output logic                irq,
  output logic                err
);
  localparam int FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] status_q;
  logic [FULL_W-1:0] mask_q;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] st_q;
    logic [HALF_W-1:0] mk_q;
    logic [HALF_W-1:0] st_nxt;
    logic [HALF_W-1:0] keep;

    assign keep   = st_wr[h] ? wdata : {HALF_W{1'b1}};
    assign st_nxt = ((st_q & keep) | evt[h*HALF_W +: HALF_W]) & STAT_IMPL[h*HALF_W +: HALF_W];

    always_ff @(posedge clk) begin
      if (rst || soft_rst) st_q <= '0;
      else                 st_q <= st_nxt;
    end

    always_ff @(posedge clk) begin
      if (rst)           mk_q <= {HALF_W{1'b1}};
      else if (mk_wr[h]) mk_q <= wdata;
    end
  end

  assign status_q = {g_half[1].st_q, g_half[0].st_q};
  assign mask_q   = {g_half[1].mk_q, g_half[0].mk_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      err <= 1'b0;
    end else begin
      irq <= |(status_q & ~mask_q);
      err <= |(status_q & ERR_GROUP);
    end
  end

  always_comb begin
    status_rd           = status_q;
    status_rd[BUSY_BIT] = busy;
  end
  assign mask_rd = mask_q;

  AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (st_wr == 2'b00 && !soft_rst) |=> ((status_q & $past(status_q)) == $past(status_q))); // R3
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
    ((|(evt & STAT_IMPL)) && !soft_rst) |=> ((status_q & $past(evt & STAT_IMPL)) == $past(evt & STAT_IMPL))); // R4
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(status_q) & ~$past(mask_q)))); // R5
  AST_ERR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err == |($past(status_q) & ERR_GROUP))); // R13
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (status_q == '0)); // R11
endmodule

// File: rtl/sdh_cmd.sv
module sdh_cmd
  import sdh_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                soft_rst,
  input  logic [HALF_W-1:0]   wdata,
  input  logic [1:0]          arg_wr,
  input  logic                cmd_wr,
  input  logic                resp_valid,
  input  logic [2*HALF_W-1:0] resp,
  output logic [2*HALF_W-1:0] arg_q,
  output logic [HALF_W-1:0]   cmd_q,
  output logic [2*HALF_W-1:0] resp_q,
  output logic                start,
  output logic [5:0]          opcode,
  output logic [2:0]          rkind,
  output logic                data,
  output logic                rd
);
  cmd_word_t cw_in;
  cmd_word_t cw_q;

  for (genvar h = 0; h < 2; h++) begin : g_arg
    logic [HALF_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)            q <= '0;
      else if (arg_wr[h]) q <= wdata;
    end
  end
  assign arg_q = {g_arg[1].q, g_arg[0].q};

  assign cw_in = cmd_word_t'(wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      cw_q  <= '0;
      start <= 1'b0;
    end else begin
      start <= cmd_wr && (cw_in.rkind >= RK_FIRST_VALID);
      if (cmd_wr) cw_q <= cw_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) resp_q <= '0;
    else if (resp_valid) resp_q <= resp;
  end

  assign cmd_q  = cw_q;
  assign opcode = cw_q.opcode;
  assign rkind  = cw_q.rkind;
  assign data   = cw_q.data;
  assign rd     = cw_q.rd;

  AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    start |-> ($past(cmd_wr) && rkind >= RK_FIRST_VALID)); // R7
  AST_RESP_HELD: assert property (@(posedge clk) disable iff (rst)
    (!resp_valid && !soft_rst) |=> $stable(resp_q)); // R12
endmodule

// File: rtl/sdh_ctrl.sv
module sdh_ctrl
  import sdh_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HALF_W-1:0] wdata,
  input  logic              clk_wr,
  input  logic              opt_wr,
  input  logic              srst_wr,
  input  logic              busy,
  output logic [HALF_W-1:0] clk_q,
  output logic [HALF_W-1:0] opt_q,
  output logic [HALF_W-1:0] srst_q,
  output logic              clk_en,
  output logic [DIV_W-1:0]  clk_div,
  output logic              bus4,
  output logic              core_rst
);
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q  <= CLK_RST_VAL;
      opt_q  <= OPT_RST_VAL;
      srst_q <= HALF_W'(1);
    end else begin
      if (clk_wr && !busy) clk_q  <= wdata;
      if (opt_wr)          opt_q  <= wdata;
      if (srst_wr)         srst_q <= HALF_W'(wdata[0]);
    end
  end

  assign clk_en   = clk_q[CLK_EN_BIT];
  assign clk_div  = clk_q[DIV_W-1:0];
  assign bus4     = ~opt_q[OPT_NARROW];
  assign core_rst = ~srst_q[0];

  AST_CLK_LOCKED: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(clk_q)); // R9
  AST_SRST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (srst_wr && wdata[0]) |=> !core_rst); // R11
endmodule

// File: rtl/sdh_regs.sv
module sdh_regs
  import sdh_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [15:0]       bus_wdata_i,
  output logic [15:0]       bus_rdata_o,
  input  logic [31:0]       evt_i,
  input  logic              cmd_busy_i,
  input  logic              resp_valid_i,
  input  logic [31:0]       resp_i,
  output logic              cmd_start_o,
  output logic [5:0]        cmd_opcode_o,
  output logic [2:0]        cmd_resp_type_o,
  output logic              cmd_data_o,
  output logic              cmd_read_o,
  output logic [31:0]       cmd_arg_o,
  output logic              irq_o,
  output logic              err_o,
  output logic              clk_en_o,
  output logic [DIV_W-1:0]  clk_div_o,
  output logic              bus4_o,
  output logic              core_rst_o
);
  localparam int HALF_W = BUS_W;
  localparam int WIDX_W = ADDR_W - 1;

  logic [WIDX_W-1:0] widx;
  assign widx = bus_addr_i[ADDR_W-1:1];

  function automatic logic hit(input logic [WIDX_W-1:0] w, input int off);
    return w == WIDX_W'(off >> 1);
  endfunction

  logic [1:0] arg_wr, st_wr, mk_wr;
  logic       cmd_wr, clk_wr, opt_wr, srst_wr;

  assign arg_wr  = {bus_wr_i && hit(widx, OFF_ARG + 2),  bus_wr_i && hit(widx, OFF_ARG)};
  assign st_wr   = {bus_wr_i && hit(widx, OFF_STAT + 2), bus_wr_i && hit(widx, OFF_STAT)};
  assign mk_wr   = {bus_wr_i && hit(widx, OFF_MASK + 2), bus_wr_i && hit(widx, OFF_MASK)};
  assign cmd_wr  = bus_wr_i && hit(widx, OFF_CMD);
  assign clk_wr  = bus_wr_i && hit(widx, OFF_CLK);
  assign opt_wr  = bus_wr_i && hit(widx, OFF_OPT);
  assign srst_wr = bus_wr_i && hit(widx, OFF_SRST);

  logic [31:0]       status_rd, mask_rd, arg_q, resp_q;
  logic [HALF_W-1:0] cmd_q, clk_q, opt_q, srst_q;

  sdh_status #(.HALF_W(HALF_W)) u_status (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (core_rst_o),
    .st_wr     (st_wr),
    .mk_wr     (mk_wr),
    .wdata     (bus_wdata_i),
    .evt       (evt_i),
    .busy      (cmd_busy_i),
    .status_rd (status_rd),
    .mask_rd   (mask_rd),
    .irq       (irq_o),
    .err       (err_o)
  );

  sdh_cmd #(.HALF_W(HALF_W)) u_cmd (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (core_rst_o),
    .wdata      (bus_wdata_i),
    .arg_wr     (arg_wr),
    .cmd_wr     (cmd_wr),
    .resp_valid (resp_valid_i),
    .resp       (resp_i),
    .arg_q      (arg_q),
    .cmd_q      (cmd_q),
    .resp_q     (resp_q),
    .start      (cmd_start_o),
    .opcode     (cmd_opcode_o),
    .rkind      (cmd_resp_type_o),
    .data       (cmd_data_o),
    .rd         (cmd_read_o)
  );

  sdh_ctrl #(.HALF_W(HALF_W), .DIV_W(DIV_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wdata    (bus_wdata_i),
    .clk_wr   (clk_wr),
    .opt_wr   (opt_wr),
    .srst_wr  (srst_wr),
    .busy     (cmd_busy_i),
    .clk_q    (clk_q),
    .opt_q    (opt_q),
    .srst_q   (srst_q),
    .clk_en   (clk_en_o),
    .clk_div  (clk_div_o),
    .bus4     (bus4_o),
    .core_rst (core_rst_o)
  );

  assign cmd_arg_o = arg_q;

  logic [HALF_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit(widx, OFF_ARG))       rd_mux = arg_q[15:0];
    if (hit(widx, OFF_ARG + 2))   rd_mux = arg_q[31:16];
    if (hit(widx, OFF_CMD))       rd_mux = cmd_q;
    if (hit(widx, OFF_CLK))       rd_mux = clk_q;
    if (hit(widx, OFF_RESP))      rd_mux = resp_q[15:0];
    if (hit(widx, OFF_RESP + 2))  rd_mux = resp_q[31:16];
    if (hit(widx, OFF_STAT))      rd_mux = status_rd[15:0];
    if (hit(widx, OFF_STAT + 2))  rd_mux = status_rd[31:16];
    if (hit(widx, OFF_MASK))      rd_mux = mask_rd[15:0];
    if (hit(widx, OFF_MASK + 2))  rd_mux = mask_rd[31:16];
    if (hit(widx, OFF_OPT))       rd_mux = opt_q;
    if (hit(widx, OFF_SRST))      rd_mux = srst_q;
  end

  always_ff @(posedge clk) begin
    if (rst)           bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_mux;
  end

  AST_STROBE_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    $countones({arg_wr, st_wr, mk_wr, cmd_wr, clk_wr, opt_wr, srst_wr}) <= 1); // R2
  AST_START_ONLY_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_start_o) |-> $past(cmd_wr)); // R7
  AST_BUSY_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && hit(widx, OFF_STAT + 2)) |=> (bus_rdata_o[BUSY_BIT-16] == $past(cmd_busy_i))); // R8
endmodule

// File: tb/tb_sdh_regs.sv
module tb_sdh_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic [31:0] evt;
  logic        busy, resp_valid;
  logic [31:0] resp;
  logic        cmd_start, cmd_data, cmd_read, irq, err, clk_en, bus4, core_rst;
  logic [5:0]  cmd_opcode;
  logic [2:0]  cmd_rtype;
  logic [31:0] cmd_arg;
  logic [7:0]  clk_div;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [31:0] IMPL = 32'h01FF_000F;
  localparam logic [31:0] ERRS = 32'h01FF_0000;

  always #5 clk = ~clk;

  sdh_regs dut (
    .clk(clk), .rst(rst), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .evt_i(evt), .cmd_busy_i(busy),
    .resp_valid_i(resp_valid), .resp_i(resp), .cmd_start_o(cmd_start),
    .cmd_opcode_o(cmd_opcode), .cmd_resp_type_o(cmd_rtype), .cmd_data_o(cmd_data),
    .cmd_read_o(cmd_read), .cmd_arg_o(cmd_arg), .irq_o(irq), .err_o(err),
    .clk_en_o(clk_en), .clk_div_o(clk_div), .bus4_o(bus4), .core_rst_o(core_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    tick();
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic pulse_evt(input logic [31:0] e);
    evt = e;
    tick();
    evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    evt = '0; busy = 0; resp_valid = 0; resp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(5'h0C, d); chk("R1 status lo", {16'h0, d}, 32'h0);
    rd(5'h10, d); chk("R1 mask lo", {16'h0, d}, 32'hFFFF);
    rd(5'h12, d); chk("R1 mask hi", {16'h0, d}, 32'hFFFF);
    rd(5'h06, d); chk("R1 clock", {16'h0, d}, 32'h0040);
    rd(5'h14, d); chk("R1 option", {16'h0, d}, 32'h80E0);
    rd(5'h16, d); chk("R1 soft reset", {16'h0, d}, 32'h0001);
    chk("R1 outputs", {28'h0, irq, err, cmd_start, core_rst}, 32'h0);

    // R2 split argument
    wr(5'h00, 16'h1234); wr(5'h02, 16'hABCD);
    chk("R2 arg out", cmd_arg, 32'hABCD1234);
    rd(5'h02, d); chk("R2 arg hi", {16'h0, d}, 32'hABCD);
    rd(5'h00, d); chk("R2 arg lo", {16'h0, d}, 32'h1234);

    // R6 R7 sweep all response kinds
    for (int c = 0; c < 8; c++) begin
      logic [15:0] w;
      logic [2:0]  k;
      k = 3'(c);
      w = {3'b0, k[1], k[0], k, 2'b0, 6'(c + 10)};
      wr(5'h04, w);
      chk("R7 start pulse", {31'h0, cmd_start}, {31'h0, (c >= 3)});
      chk("R6 decode", {20'h0, cmd_read, cmd_data, cmd_rtype, cmd_opcode},
          {20'h0, k[1], k[0], k, 6'(c + 10)});
      tick();
      chk("R7 pulse one cycle", {31'h0, cmd_start}, 32'h0);
      rd(5'h04, d); chk("R6 cmd readback", {16'h0, d}, {16'h0, w});
    end

    // R3 R4 R5 R13 sweep every event bit
    for (int b = 0; b < 32; b++) begin
      logic [31:0] bit_m;
      logic [4:0]  ha;
      bit_m = 32'h1 << b;
      ha = (b >= 16) ? 5'h0E : 5'h0C;
      wr(5'h10, ~bit_m[15:0]); wr(5'h12, ~bit_m[31:16]);
      pulse_evt(bit_m);
      tick();
      chk("R5 irq on unmasked", {31'h0, irq}, {31'h0, (IMPL[b] && b != 30)});
      chk("R13 err flag", {31'h0, err}, {31'h0, ERRS[b]});
      rd(ha, d);
      chk("R4 status set", {16'h0, d}, {16'h0, (b >= 16) ? (bit_m[31:16] & IMPL[31:16]) : (bit_m[15:0] & IMPL[15:0])});
      wr(ha, (b >= 16) ? ~bit_m[31:16] : ~bit_m[15:0]);
      tick();
      rd(ha, d); chk("R3 write zero clears", {16'h0, d}, 32'h0);
      chk("R5 irq drops", {31'h0, irq}, 32'h0);
    end

    // R3 write one keeps, R5 masked bit gives no irq
    wr(5'h10, 16'hFFFF); wr(5'h12, 16'hFFFF);
    pulse_evt(32'h0001_0005);
    wr(5'h0C, 16'hFFFB); wr(5'h0E, 16'hFFFF);
    rd(5'h0C, d); chk("R3 write one keeps", {16'h0, d}, 32'h0001);
    rd(5'h0E, d); chk("R3 hi kept", {16'h0, d}, 32'h0001);
    chk("R5 masked no irq", {31'h0, irq}, 32'h0);
    chk("R13 err ignores mask", {31'h0, err}, 32'h1);
    wr(5'h0C, 16'h0000); wr(5'h0E, 16'h0000);

    // R4 set wins over same-cycle clear
    bus_addr = 5'h0C; bus_wdata = 16'h0000; bus_wr = 1'b1; evt = 32'h0000_0002;
    tick();
    bus_wr = 1'b0; evt = '0;
    rd(5'h0C, d); chk("R4 set beats clear", {16'h0, d}, 32'h0002);
    wr(5'h0C, 16'h0000);

    // R8 busy visible and not writable
    busy = 1'b1;
    wr(5'h0E, 16'h0000);
    rd(5'h0E, d); chk("R8 busy bit", {16'h0, d}, 32'h4000);
    // R9 clock write refused while busy
    wr(5'h06, 16'h0140);
    rd(5'h06, d); chk("R9 clock locked", {16'h0, d}, 32'h0040);
    busy = 1'b0;
    rd(5'h0E, d); chk("R8 busy clear", {16'h0, d}, 32'h0);
    wr(5'h06, 16'h0140);
    chk("R9 clock fields", {23'h0, clk_en, clk_div}, 32'h0000_0140);

    // R10 option bus width
    wr(5'h14, 16'h00E0); chk("R10 4-bit", {31'h0, bus4}, 32'h1);
    wr(5'h14, 16'h80E0); chk("R10 1-bit", {31'h0, bus4}, 32'h0);

    // R12 response capture
    resp = 32'hDEADBEEF; resp_valid = 1'b1; tick(); resp_valid = 1'b0; resp = '0;
    rd(5'h08, d); chk("R12 resp lo", {16'h0, d}, 32'hBEEF);
    rd(5'h0A, d); chk("R12 resp hi", {16'h0, d}, 32'hDEAD);

    // R11 soft reset
    pulse_evt(32'h0000_0001);
    wr(5'h16, 16'h0000);
    chk("R11 core reset", {31'h0, core_rst}, 32'h1);
    pulse_evt(32'h0100_0008);
    tick();
    rd(5'h0C, d); chk("R11 status held clear", {16'h0, d}, 32'h0);
    rd(5'h0E, d); chk("R11 status hi clear", {16'h0, d}, 32'h0);
    wr(5'h16, 16'h0001);
    chk("R11 core released", {31'h0, core_rst}, 32'h0);
    rd(5'h08, d); chk("R11 resp cleared", {16'h0, d}, 32'h0);
    pulse_evt(32'h0000_0004);
    rd(5'h0C, d); chk("R11 events resume", {16'h0, d}, 32'h0004);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule